// File: doc/BRIEF.md
# Filtered Branch Trace Buffer

This block sits beside a processor pipeline and observes every retired branch. Each event brings a source address, a target address, a taken flag, a target-prediction-correct flag, a predicate-prediction-correct flag and a two-bit branch kind. Four programmable filters decide whether the branch qualifies. Qualifying branches go into a four-slot ring, which always holds the newest qualifying branches in arrival order.

A cycle counter runs in parallel with a programmable period. When the period expires, the ring stops accepting branches and a sticky interrupt rises. Software then reads the frozen branch vector through a combinational read port. Index 0 returns the oldest valid entry. Software then pulses a clear, which empties the ring, drops the interrupt and restarts the count.

Top module: `brtrace_top`

## Requirements
- R1: Synchronous active-low reset leaves `irq` low and every read index returning `rd_valid` = 0.
- R2: The taken filter mode `cfg_taken_mode` selects between four options. 00 passes any branch. 01 passes only taken branches. 10 passes only not-taken branches. 11 passes nothing.
- R3: The target filter `cfg_tgt_mode` uses the same encoding on `br_tgt_ok`. 01 passes a correctly predicted target, 10 passes a mispredicted target, and 11 passes nothing.
- R4: The predicate filter `cfg_pred_mode` uses the same encoding on `br_pred_ok`. 01 passes a correct predicate prediction, 10 passes a wrong one, and 11 passes nothing.
- R5: Branch kind is coded 00 = IP-relative, 01 = indirect, 10 = return, 11 = other. The kind filter `cfg_kind_mode` passes any kind with 00, indirect only with 01, return only with 10, and IP-relative only with 11.
- R6: A branch is recorded only when `br_valid` is high, `cfg_enable` is high and all four filters pass in the same cycle.
- R7: The ring keeps the four most recent recorded branches. `rd_idx` 0 returns the oldest and higher indices return newer ones. Each entry returns the source, target, the three flags and the kind exactly as recorded.
- R8: An index at or beyond the number of recorded entries reads back with `rd_valid` = 0.
- R9: After reset or a clear, `irq` rises on the Nth rising edge, where N = `cfg_period`. A period of 0 behaves as 1. A branch presented on that edge is still recorded.
- R10: While `irq` is high and no clear is applied, `irq` stays high, the ring contents stay unchanged, and no branch is recorded.
- R11: A clear pulse on `irq_clear` takes effect on the next edge. It drops `irq`, invalidates every entry, ignores any branch in that cycle, and restarts the period count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_valid | input | 1 | A retired branch is present this cycle |
| br_src | input | ADDR_W | Branch instruction address |
| br_dst | input | ADDR_W | Branch target address |
| br_taken | input | 1 | Branch was taken |
| br_tgt_ok | input | 1 | Target was predicted correctly |
| br_pred_ok | input | 1 | Predicate was predicted correctly |
| br_kind | input | 2 | Branch kind (00 IP-relative, 01 indirect, 10 return, 11 other) |
| cfg_enable | input | 1 | Recording enable |
| cfg_taken_mode | input | 2 | Taken filter mode |
| cfg_tgt_mode | input | 2 | Target-prediction filter mode |
| cfg_pred_mode | input | 2 | Predicate-prediction filter mode |
| cfg_kind_mode | input | 2 | Kind filter mode |
| cfg_period | input | PERIOD_W | Sampling period in cycles |
| irq_clear | input | 1 | Clear pulse: empties ring, drops irq, restarts count |
| irq | output | 1 | Sticky sample interrupt, ring frozen while high |
| rd_idx | input | log2(DEPTH) | Read index, 0 = oldest |
| rd_valid | output | 1 | Selected entry holds a recorded branch |
| rd_src | output | ADDR_W | Source address of selected entry |
| rd_dst | output | ADDR_W | Target address of selected entry |
| rd_taken | output | 1 | Taken flag of selected entry |
| rd_tgt_ok | output | 1 | Target-prediction flag of selected entry |
| rd_pred_ok | output | 1 | Predicate-prediction flag of selected entry |
| rd_kind | output | 2 | Kind of selected entry |

## Verification
The hardest situation to reach from the ports is a freeze that lands while the ring has already wrapped. In that case the oldest entry sits at the head slot rather than at slot 0, and branches keep arriving during the frozen window. Short random periods (3 to 40 cycles) are mixed with a high branch rate and mostly permissive filter settings. This lets the ring wrap several times between expiries. Clears are applied at random delays after the interrupt, so the bench reads many frozen vectors with an offset head and many clear-versus-expiry alignments. Directed runs cover each filter mode one at a time, a period of 0, and branches offered while frozen.

// File: rtl/brtrace_pkg.sv
// Shared types and helpers for the filtered branch trace buffer.
// Assumes the 2-bit mode and kind encodings documented in the brief.
package brtrace_pkg;

    typedef enum logic [1:0] {
        FLT_ALL  = 2'b00,
        FLT_SET  = 2'b01,
        FLT_CLR  = 2'b10,
        FLT_NONE = 2'b11
    } flt_mode_e;

    typedef enum logic [1:0] {
        KIND_IPREL = 2'b00,
        KIND_INDIR = 2'b01,
        KIND_RET   = 2'b10,
        KIND_OTHER = 2'b11
    } br_kind_e;

    typedef struct packed {
        logic       taken;
        logic       tgt_ok;
        logic       pred_ok;
        logic [1:0] kind;
    } br_flags_t;

    // Evaluate one flag filter: all / flag set / flag clear / none
    function automatic logic flag_match(input logic [1:0] mode, input logic flag);
        logic hit;
        case (flt_mode_e'(mode))
            FLT_ALL:  hit = 1'b1;
            FLT_SET:  hit = flag;
            FLT_CLR:  hit = ~flag;
            default:  hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/brtrace_filter.sv
// Qualification logic: a branch passes only when recording is enabled and
// all three flag filters plus the kind filter accept it. Purely combinational.
module brtrace_filter
    import brtrace_pkg::*;
(
    input  br_flags_t  flags,
    input  logic       enable,
    input  logic [1:0] taken_mode,
    input  logic [1:0] tgt_mode,
    input  logic [1:0] pred_mode,
    input  logic [1:0] kind_mode,
    output logic       pass
);
    localparam int NFLAG = 3;

    logic [NFLAG-1:0]      flag_vec;
    logic [NFLAG-1:0][1:0] mode_vec;
    logic [NFLAG-1:0]      flag_hit;
    logic                  kind_hit;

    assign flag_vec = {flags.pred_ok, flags.tgt_ok, flags.taken};
    assign mode_vec = {pred_mode, tgt_mode, taken_mode};

    // One identical filter per outcome/prediction flag
    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        assign flag_hit[g] = flag_match(mode_vec[g], flag_vec[g]);
    end

    // Kind filter: all, indirect, return, IP-relative
    always_comb begin
        case (kind_mode)
            2'b00:   kind_hit = 1'b1;
            2'b01:   kind_hit = (br_kind_e'(flags.kind) == KIND_INDIR);
            2'b10:   kind_hit = (br_kind_e'(flags.kind) == KIND_RET);
            default: kind_hit = (br_kind_e'(flags.kind) == KIND_IPREL);
        endcase
    end

    assign pass = enable & (&flag_hit) & kind_hit;

endmodule

// File: rtl/brtrace_ring.sv
// Circular history of recorded branches with a wrapping head pointer and a
// fill count. Read port maps index 0 to the oldest valid entry.
// Assumes DEPTH is a power of two and at least 2.
module brtrace_ring
    import brtrace_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_src,
    input  logic [ADDR_W-1:0]          wr_dst,
    input  br_flags_t                  wr_flags,
    input  logic [$clog2(DEPTH)-1:0]   rd_idx,
    output logic                       rd_valid,
    output logic [ADDR_W-1:0]          rd_src,
    output logic [ADDR_W-1:0]          rd_dst,
    output br_flags_t                  rd_flags,
    output logic [$clog2(DEPTH+1)-1:0] fill,
    output logic [$clog2(DEPTH)-1:0]   head
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ADDR_W-1:0] src_q [DEPTH];
    logic [ADDR_W-1:0] dst_q [DEPTH];
    br_flags_t         flg_q [DEPTH];
    logic              vld_q [DEPTH];
    logic [IDX_W-1:0]  head_q;
    logic [CNT_W-1:0]  fill_q;
    logic [IDX_W-1:0]  oldest;
    logic [IDX_W-1:0]  slot;

    // Per-slot storage, written when the head points at it
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                vld_q[g] <= 1'b0;
                src_q[g] <= '0;
                dst_q[g] <= '0;
                flg_q[g] <= '0;
            end else if (wr_en && head_q == IDX_W'(g)) begin
                vld_q[g] <= 1'b1;
                src_q[g] <= wr_src;
                dst_q[g] <= wr_dst;
                flg_q[g] <= wr_flags;
            end
        end
    end

    // Head advance and saturating fill count
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            head_q <= '0;
            fill_q <= '0;
        end else if (wr_en) begin
            head_q <= head_q + 1'b1;
            if (fill_q != CNT_W'(DEPTH)) begin
                fill_q <= fill_q + 1'b1;
            end
        end
    end

    // Map logical read index onto a physical slot
    always_comb begin
        oldest   = (fill_q == CNT_W'(DEPTH)) ? head_q : '0;
        slot     = oldest + rd_idx;
        rd_valid = vld_q[slot];
        rd_src   = src_q[slot];
        rd_dst   = dst_q[slot];
        rd_flags = flg_q[slot];
    end

    assign fill = fill_q;
    assign head = head_q;

endmodule

// File: rtl/brtrace_sampler.sv
// Period counter and sticky interrupt. Counts cycles while not frozen; on
// expiry raises irq and reloads. A period of 0 is treated as 1.
module brtrace_sampler #(
    parameter int PERIOD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic [PERIOD_W-1:0] period,
    output logic                irq
);
    logic [PERIOD_W-1:0] cnt_q;
    logic [PERIOD_W:0]   cnt_inc;
    logic                irq_q;
    logic                expire;

    assign cnt_inc = {1'b0, cnt_q} + 1'b1;
    assign expire  = !irq_q && (cnt_inc >= {1'b0, period});

    // Count, expire into sticky irq, hold while frozen
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
            irq_q <= 1'b0;
        end else if (expire) begin
            cnt_q <= '0;
            irq_q <= 1'b1;
        end else if (!irq_q) begin
            cnt_q <= cnt_inc[PERIOD_W-1:0];
        end
    end

    assign irq = irq_q;

endmodule

// File: rtl/brtrace_top.sv
// Filtered branch trace buffer top: filters retired branches, records the
// qualifying ones into a ring, freezes on period expiry with a sticky irq.
// Assumes one branch event per cycle at most and a clear pulse from software.
module brtrace_top
    import brtrace_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DEPTH    = 4,
    parameter int PERIOD_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     br_valid,
    input  logic [ADDR_W-1:0]        br_src,
    input  logic [ADDR_W-1:0]        br_dst,
    input  logic                     br_taken,
    input  logic                     br_tgt_ok,
    input  logic                     br_pred_ok,
    input  logic [1:0]               br_kind,
    input  logic                     cfg_enable,
    input  logic [1:0]               cfg_taken_mode,
    input  logic [1:0]               cfg_tgt_mode,
    input  logic [1:0]               cfg_pred_mode,
    input  logic [1:0]               cfg_kind_mode,
    input  logic [PERIOD_W-1:0]      cfg_period,
    input  logic                     irq_clear,
    output logic                     irq,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic                     rd_valid,
    output logic [ADDR_W-1:0]        rd_src,
    output logic [ADDR_W-1:0]        rd_dst,
    output logic                     rd_taken,
    output logic                     rd_tgt_ok,
    output logic                     rd_pred_ok,
    output logic [1:0]               rd_kind
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    br_flags_t        in_flags;
    br_flags_t        out_flags;
    logic             pass;
    logic             record;
    logic [CNT_W-1:0] fill_cnt;
    logic [IDX_W-1:0] head_ptr;

    assign in_flags = '{taken: br_taken, tgt_ok: br_tgt_ok,
                        pred_ok: br_pred_ok, kind: br_kind};

    brtrace_filter u_filter (
        .flags      (in_flags),
        .enable     (cfg_enable),
        .taken_mode (cfg_taken_mode),
        .tgt_mode   (cfg_tgt_mode),
        .pred_mode  (cfg_pred_mode),
        .kind_mode  (cfg_kind_mode),
        .pass       (pass)
    );

    // Record only when qualified, not frozen, and no clear in flight
    assign record = br_valid && pass && !irq && !irq_clear;

    brtrace_ring #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (irq_clear),
        .wr_en    (record),
        .wr_src   (br_src),
        .wr_dst   (br_dst),
        .wr_flags (in_flags),
        .rd_idx   (rd_idx),
        .rd_valid (rd_valid),
        .rd_src   (rd_src),
        .rd_dst   (rd_dst),
        .rd_flags (out_flags),
        .fill     (fill_cnt),
        .head     (head_ptr)
    );

    brtrace_sampler #(.PERIOD_W(PERIOD_W)) u_sampler (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (irq_clear),
        .period (cfg_period),
        .irq    (irq)
    );

    assign rd_taken   = out_flags.taken;
    assign rd_tgt_ok  = out_flags.tgt_ok;
    assign rd_pred_ok = out_flags.pred_ok;
    assign rd_kind    = out_flags.kind;

endmodule

// File: rtl/brtrace_chk.sv
// Property checker for brtrace_top, attached by bind. Observes the irq,
// clear, enable, read port and the ring's fill count and head pointer.
module brtrace_chk #(
    parameter int DEPTH = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       irq,
    input logic                       irq_clear,
    input logic                       cfg_enable,
    input logic [$clog2(DEPTH)-1:0]   rd_idx,
    input logic                       rd_valid,
    input logic [$clog2(DEPTH+1)-1:0] fill,
    input logic [$clog2(DEPTH)-1:0]   head
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq && fill == '0));

    // R6
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_enable && !irq_clear) |=> $stable(head));

    // R7
    fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill != $past(fill)) |-> (fill == '0 || fill == $past(fill) + 1'b1));

    // R8
    unfilled_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (CNT_W'(rd_idx) >= fill) |-> !rd_valid);

    // R10
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clear) |=> irq);

    // R10
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clear) |=> ($stable(head) && $stable(fill)));

    // R11
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clear |=> (!irq && fill == '0));

endmodule

bind brtrace_top brtrace_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq        (irq),
    .irq_clear  (irq_clear),
    .cfg_enable (cfg_enable),
    .rd_idx     (rd_idx),
    .rd_valid   (rd_valid),
    .fill       (fill_cnt),
    .head       (head_ptr)
);

// File: tb/brtrace_top_bench.sv
// Self-checking bench: seeded random branches and configurations plus
// directed filter, period, freeze and clear cases, against a bench model.
module brtrace_top_bench;
    localparam int ADDR_W = 32;
    localparam int DEPTH  = 4;

    typedef struct {
        logic [31:0] s;
        logic [31:0] d;
        logic        t;
        logic        g;
        logic        p;
        logic [1:0]  k;
    } rec_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid = 1'b0;
    logic [31:0] br_src = '0;
    logic [31:0] br_dst = '0;
    logic        br_taken = 1'b0;
    logic        br_tgt_ok = 1'b0;
    logic        br_pred_ok = 1'b0;
    logic [1:0]  br_kind = '0;
    logic        cfg_enable = 1'b1;
    logic [1:0]  cfg_taken_mode = '0;
    logic [1:0]  cfg_tgt_mode = '0;
    logic [1:0]  cfg_pred_mode = '0;
    logic [1:0]  cfg_kind_mode = '0;
    logic [31:0] cfg_period = 32'd1000;
    logic        irq_clear = 1'b0;
    logic        irq;
    logic [1:0]  rd_idx = '0;
    logic        rd_valid;
    logic [31:0] rd_src;
    logic [31:0] rd_dst;
    logic        rd_taken;
    logic        rd_tgt_ok;
    logic        rd_pred_ok;
    logic [1:0]  rd_kind;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;
    bit   m_irq = 1'b0;
    int   m_cnt = 0;
    rec_t mq[$];

    always #5 clk = ~clk;

    brtrace_top #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .PERIOD_W(32)) u_brtrace_top (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_src(br_src),
        .br_dst(br_dst), .br_taken(br_taken), .br_tgt_ok(br_tgt_ok),
        .br_pred_ok(br_pred_ok), .br_kind(br_kind), .cfg_enable(cfg_enable),
        .cfg_taken_mode(cfg_taken_mode), .cfg_tgt_mode(cfg_tgt_mode),
        .cfg_pred_mode(cfg_pred_mode), .cfg_kind_mode(cfg_kind_mode),
        .cfg_period(cfg_period), .irq_clear(irq_clear), .irq(irq),
        .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_src(rd_src), .rd_dst(rd_dst),
        .rd_taken(rd_taken), .rd_tgt_ok(rd_tgt_ok), .rd_pred_ok(rd_pred_ok),
        .rd_kind(rd_kind)
    );

    // Flag filter per R2/R3/R4: 00 all, 01 flag set, 10 flag clear, 11 none
    function automatic bit mode_ok(input logic [1:0] m, input logic f);
        case (m)
            2'b00:   return 1'b1;
            2'b01:   return f;
            2'b10:   return !f;
            default: return 1'b0;
        endcase
    endfunction

    // Kind filter per R5
    function automatic bit kind_ok(input logic [1:0] m, input logic [1:0] k);
        case (m)
            2'b00:   return 1'b1;
            2'b01:   return k == 2'b01;
            2'b10:   return k == 2'b10;
            default: return k == 2'b00;
        endcase
    endfunction

    // Expected qualification per R6
    function automatic bit exp_pass();
        return br_valid && cfg_enable && mode_ok(cfg_taken_mode, br_taken)
            && mode_ok(cfg_tgt_mode, br_tgt_ok) && mode_ok(cfg_pred_mode, br_pred_ok)
            && kind_ok(cfg_kind_mode, br_kind);
    endfunction

    // Expected state change at a rising edge, from R1 and R6..R11
    task automatic model_edge();
        int per;
        rec_t r;
        per = (cfg_period == 0) ? 1 : int'(cfg_period);
        if (!rst_n || irq_clear) begin
            m_irq = 1'b0;
            m_cnt = 0;
            mq.delete();
        end else if (!m_irq) begin
            if (exp_pass()) begin
                r.s = br_src; r.d = br_dst; r.t = br_taken;
                r.g = br_tgt_ok; r.p = br_pred_ok; r.k = br_kind;
                mq.push_back(r);
                if (mq.size() > DEPTH) void'(mq.pop_front());
            end
            if (m_cnt + 1 >= per) begin
                m_irq = 1'b1;
                m_cnt = 0;
            end else begin
                m_cnt++;
            end
        end
    endtask

    task automatic check_ring(input string tag);
        for (int i = 0; i < DEPTH; i++) begin
            bit ev;
            bit bad;
            rd_idx = 2'(i);
            #1;
            n_checks++;
            ev = (i < mq.size());
            bad = (rd_valid !== ev);
            if (ev && !bad)
                bad = (rd_src !== mq[i].s) || (rd_dst !== mq[i].d) ||
                      (rd_taken !== mq[i].t) || (rd_tgt_ok !== mq[i].g) ||
                      (rd_pred_ok !== mq[i].p) || (rd_kind !== mq[i].k);
            if (bad) begin
                n_errors++;
                if (ev)
                    $display("FAIL %s idx%0d: got v=%b src=%h dst=%h f=%b%b%b k=%0d exp v=1 src=%h dst=%h f=%b%b%b k=%0d",
                             tag, i, rd_valid, rd_src, rd_dst, rd_taken, rd_tgt_ok, rd_pred_ok, rd_kind,
                             mq[i].s, mq[i].d, mq[i].t, mq[i].g, mq[i].p, mq[i].k);
                else
                    $display("FAIL %s idx%0d: got valid=%b exp valid=0", tag, i, rd_valid);
            end
        end
    endtask

    // One clock: update model, then sample irq and optionally the ring
    task automatic cyc(input string tag, input bit ring_chk);
        @(posedge clk);
        model_edge();
        #1;
        n_checks++;
        if (irq !== m_irq) begin
            n_errors++;
            $display("FAIL %s irq: got %b exp %b", tag, irq, m_irq);
        end
        if (ring_chk) check_ring(tag);
    endtask

    task automatic rand_branch();
        br_valid   = ($urandom % 4) != 0;
        br_src     = $urandom;
        br_dst     = $urandom;
        br_taken   = $urandom % 2;
        br_tgt_ok  = $urandom % 2;
        br_pred_ok = $urandom % 2;
        br_kind    = 2'($urandom % 4);
    endtask

    task automatic set_modes(input logic [1:0] a, input logic [1:0] b,
                             input logic [1:0] c, input logic [1:0] d);
        cfg_taken_mode = a; cfg_tgt_mode = b; cfg_pred_mode = c; cfg_kind_mode = d;
    endtask

    task automatic do_clear(input string tag);
        br_valid = 1'b1;
        irq_clear = 1'b1;
        cyc(tag, 1'b1);
        irq_clear = 1'b0;
        br_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    // Watchdog: hung run is a failed check
    initial begin
        #(10 * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    initial begin
        string ftag[4];
        ftag[0] = "R2"; ftag[1] = "R3"; ftag[2] = "R4"; ftag[3] = "R5";
        void'($urandom(32'd20240611));

        // R1: reset state
        rst_n = 1'b0;
        cyc("R1", 1'b0);
        cyc("R1", 1'b1);
        rst_n = 1'b1;

        // R8: partially filled ring, unfilled slots invalid
        rand_branch(); br_valid = 1'b1;
        cyc("R8", 1'b1);
        rand_branch(); br_valid = 1'b1;
        cyc("R8", 1'b1);
        br_valid = 1'b0;

        // R7: wrap the ring, oldest first
        for (int i = 0; i < 7; i++) begin
            rand_branch(); br_valid = 1'b1;
            cyc("R7", 1'b1);
        end

        // R2..R5: each filter through its four modes
        for (int f = 0; f < 4; f++) begin
            for (int m = 0; m < 4; m++) begin
                set_modes(f == 0 ? 2'(m) : 2'b00, f == 1 ? 2'(m) : 2'b00,
                          f == 2 ? 2'(m) : 2'b00, f == 3 ? 2'(m) : 2'b00);
                do_clear(ftag[f]);
                for (int i = 0; i < 12; i++) begin
                    rand_branch();
                    cyc(ftag[f], 1'b1);
                end
            end
        end

        // R6: combined filters, then recording disabled
        set_modes(2'b01, 2'b00, 2'b10, 2'b00);
        do_clear("R6");
        for (int i = 0; i < 20; i++) begin rand_branch(); cyc("R6", 1'b1); end
        set_modes(2'b00, 2'b00, 2'b00, 2'b00);
        cfg_enable = 1'b0;
        for (int i = 0; i < 8; i++) begin rand_branch(); br_valid = 1'b1; cyc("R6", 1'b1); end
        cfg_enable = 1'b1;

        // R9: period 7 and period 0
        cfg_period = 32'd7;
        do_clear("R9");
        for (int i = 0; i < 8; i++) begin rand_branch(); br_valid = 1'b1; cyc("R9", 1'b1); end
        cfg_period = 32'd0;
        do_clear("R9");
        rand_branch(); br_valid = 1'b1;
        cyc("R9", 1'b1);

        // R10: frozen ring ignores branches
        cfg_period = 32'd5;
        do_clear("R10");
        for (int i = 0; i < 14; i++) begin rand_branch(); br_valid = 1'b1; cyc("R10", 1'b1); end

        // R11: clear empties, drops irq, restarts count
        do_clear("R11");
        br_valid = 1'b0;
        for (int i = 0; i < 6; i++) cyc("R11", 1'b1);

        // Random mix: short periods, random clears and configurations
        cfg_period = 32'd3 + ($urandom % 38);
        for (int i = 0; i < 4000; i++) begin
            rand_branch();
            if ($urandom % 40 == 0) begin
                set_modes(($urandom % 6) > 3 ? 2'($urandom % 4) : 2'b00,
                          ($urandom % 6) > 3 ? 2'($urandom % 4) : 2'b00,
                          ($urandom % 6) > 3 ? 2'($urandom % 4) : 2'b00,
                          ($urandom % 6) > 3 ? 2'($urandom % 4) : 2'b00);
                cfg_enable = ($urandom % 8) != 0;
            end
            irq_clear = (m_irq && ($urandom % 4 == 0)) || ($urandom % 200 == 0);
            if (irq_clear && ($urandom % 3 == 0)) cfg_period = 32'($urandom % 41);
            cyc("R7", 1'b1);
        end
        irq_clear = 1'b0;

        finish_run();
    end

endmodule